// File: doc/BRIEF.md
# Card Slot Detect and Interrupt Controller

This block watches a removable flash card socket. It brings the card-present, write-protect and busy pins into the clock domain and filters the presence pin, so that contact bounce during insertion or extraction does not register as a card event. It reports the filtered slot state through a small status register. Each confirmed insertion or extraction is latched as a pending event.

The pending events drive a single level-sensitive interrupt line. Software enables the insert and remove interrupts separately and also sets a global enable, which gates both. The usual pattern is to arm only the event opposite to the current card state: remove while a card is seated, insert while the slot is empty. After an event, software waits for the card to settle and then clears the event by writing ones to the event register.

Register access uses a single-cycle write strobe with a 2-bit address. Read data is a combinational function of the address.

Top module: `cdi_card_detect`

## Requirements
- R1: The status register (address 0) reads bit0 = filtered presence, bit1 = write-protect, bit2 = busy and bit3 = ready, where ready is the inverse of busy. Write-protect and busy pass through a two-flop synchronizer.
- R2: The filtered presence changes only after the synchronized presence pin has differed from it on 16 consecutive sample ticks, with one tick every TICK_DIV clocks. A shorter pulse leaves the presence unchanged and sets no event.
- R3: A rising edge of the filtered presence sets the insert event (event register bit0), and a falling edge sets the remove event (bit1). Both events are set whatever the enable settings are.
- R4: The enable register (address 1) holds bit0 = insert enable, bit1 = remove enable and bit2 = global enable. It reads back as written.
- R5: irq_o is high exactly when the global enable is set and at least one pending event has its own enable set.
- R6: Writing the event register (address 2) clears each event bit written as one. Event bits written as zero keep their value.
- R7: If a clear and a new event hit the same event bit in the same cycle, the bit ends up set.
- R8: With the global enable clear, irq_o stays low even when an enabled event is pending.
- R9: After reset, the filtered presence, the enable register, the event register and irq_o are all zero.
- R10: Address 3 reads as zero. A write to the status register changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| card_present_i | input | 1 | Raw card-present pin |
| card_wp_i | input | 1 | Raw write-protect pin |
| card_busy_i | input | 1 | Raw card busy pin |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 3 | Register write data |
| reg_rdata_o | output | 4 | Register read data for reg_addr_i |
| irq_o | output | 1 | Level interrupt output |

## Verification
Register writes take effect at the clock edge that samples the strobe. Read data and irq_o follow in the same cycle, because both are combinational functions of the register state. The bench therefore issues one access per cycle and compares at the falling edge that follows.

Write-protect and busy appear two edges after the pin changes, and the bench waits four edges before it reads them. A presence change needs between 15·TICK_DIV+3 and 16·TICK_DIV+3 clocks, depending on the phase of the free-running tick. The bench checks that the event is still absent at 14·TICK_DIV clocks and present after a margin beyond the maximum.

The same-cycle collision of a clear and a new event is forced by holding the clear write on every cycle while a card is inserted. The bench then expects exactly one cycle of interrupt.

// File: rtl/cdi_pkg.sv
`timescale 1ns/1ps
package cdi_pkg;
  localparam int RD_W = 4;
  localparam int WR_W = 3;

  typedef enum logic [1:0] {
    ADR_STAT  = 2'd0,
    ADR_IRQEN = 2'd1,
    ADR_EVT   = 2'd2,
    ADR_RSVD  = 2'd3
  } cdi_addr_e;

  localparam int EN_INS  = 0;
  localparam int EN_REM  = 1;
  localparam int EN_GLOB = 2;
  localparam int EV_INS  = 0;
  localparam int EV_REM  = 1;
endpackage

// File: rtl/cdi_sync.sv
`timescale 1ns/1ps
module cdi_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/cdi_debounce.sv
`timescale 1ns/1ps
module cdi_debounce #(
  parameter int TICK_DIV     = 4,
  parameter int STABLE_TICKS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int CNT_W = (STABLE_TICKS > 1) ? $clog2(STABLE_TICKS) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICK_DIV - 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STABLE_TICKS - 1);

  logic [DIV_W-1:0] div_q, div_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             lvl_q, lvl_d;
  logic             tick;

  always_comb begin
    tick  = (div_q == DIV_LAST);
    div_d = tick ? '0 : div_q + 1'b1;
    lvl_d = lvl_q;
    cnt_d = cnt_q;
    if (din_i == lvl_q) begin
      cnt_d = '0;
    end else if (tick) begin
      if (cnt_q == CNT_LAST) begin
        lvl_d = din_i;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
    rise_o = lvl_d & ~lvl_q;
    fall_o = ~lvl_d & lvl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else begin
      div_q <= div_d;
      cnt_q <= cnt_d;
      lvl_q <= lvl_d;
    end
  end

  assign level_o = lvl_q;
endmodule

// File: rtl/cdi_irq_regs.sv
`timescale 1ns/1ps
module cdi_irq_regs
  import cdi_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we_i,
  input  logic [1:0]      addr_i,
  input  logic [WR_W-1:0] wdata_i,
  input  logic            ins_evt_i,
  input  logic            rem_evt_i,
  output logic [2:0]      en_o,
  output logic [1:0]      pend_o,
  output logic            irq_o
);
  logic [2:0] en_q;
  logic [1:0] pend_q, pend_d, clr_mask, new_evt;
  logic       en_wr, pend_upd;

  always_comb begin
    en_wr    = we_i && (addr_i == ADR_IRQEN);
    clr_mask = (we_i && (addr_i == ADR_EVT)) ? wdata_i[1:0] : 2'b00;
    new_evt  = '0;
    new_evt[EV_INS] = ins_evt_i;
    new_evt[EV_REM] = rem_evt_i;
    pend_d   = (pend_q & ~clr_mask) | new_evt;
    pend_upd = (clr_mask != 2'b00) || (new_evt != 2'b00);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (en_wr) begin
      en_q <= wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else if (pend_upd) begin
      pend_q <= pend_d;
    end
  end

  assign en_o   = en_q;
  assign pend_o = pend_q;
  assign irq_o  = en_q[EN_GLOB] &
                  ((en_q[EN_INS] & pend_q[EV_INS]) | (en_q[EN_REM] & pend_q[EV_REM]));
endmodule

// File: rtl/cdi_card_detect.sv
`timescale 1ns/1ps
module cdi_card_detect
  import cdi_pkg::*;
#(
  parameter int TICK_DIV     = 4,
  parameter int STABLE_TICKS = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            card_present_i,
  input  logic            card_wp_i,
  input  logic            card_busy_i,
  input  logic            reg_we_i,
  input  logic [1:0]      reg_addr_i,
  input  logic [WR_W-1:0] reg_wdata_i,
  output logic [RD_W-1:0] reg_rdata_o,
  output logic            irq_o
);
  logic [1:0] rst_pipe_q;
  logic       rst_sn;
  logic [2:0] sync_vec;
  logic       deb_present, ins_evt, rem_evt;
  logic [2:0] en_q;
  logic [1:0] pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sn = rst_pipe_q[1];

  cdi_sync #(.W(3)) u_sync (
    .clk   (clk),
    .rst_n (rst_sn),
    .d_i   ({card_busy_i, card_wp_i, card_present_i}),
    .q_o   (sync_vec)
  );

  cdi_debounce #(.TICK_DIV(TICK_DIV), .STABLE_TICKS(STABLE_TICKS)) u_deb (
    .clk     (clk),
    .rst_n   (rst_sn),
    .din_i   (sync_vec[0]),
    .level_o (deb_present),
    .rise_o  (ins_evt),
    .fall_o  (rem_evt)
  );

  cdi_irq_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_sn),
    .we_i      (reg_we_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .ins_evt_i (ins_evt),
    .rem_evt_i (rem_evt),
    .en_o      (en_q),
    .pend_o    (pend_q),
    .irq_o     (irq_o)
  );

  always_comb begin
    unique case (reg_addr_i)
      ADR_STAT:  reg_rdata_o = {~sync_vec[2], sync_vec[2], sync_vec[1], deb_present};
      ADR_IRQEN: reg_rdata_o = {1'b0, en_q};
      ADR_EVT:   reg_rdata_o = {2'b00, pend_q};
      default:   reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/cdi_card_detect_chk.sv
`timescale 1ns/1ps
module cdi_card_detect_chk (
  input logic       clk,
  input logic       rst_sn,
  input logic       reg_we_i,
  input logic [1:0] reg_addr_i,
  input logic [2:0] reg_wdata_i,
  input logic [2:0] sync_vec,
  input logic       deb_present,
  input logic       ins_evt,
  input logic       rem_evt,
  input logic [2:0] en_q,
  input logic [1:0] pend_q,
  input logic       irq_o
);
  p_deb_follow_r2: assert property (@(posedge clk) disable iff (!rst_sn)
    !$stable(deb_present) |-> (deb_present == $past(sync_vec[0])));

  p_ins_sticky_r3: assert property (@(posedge clk) disable iff (!rst_sn)
    (pend_q[0] && !(reg_we_i && reg_addr_i == 2'd2 && reg_wdata_i[0])) |=> pend_q[0]);

  p_en_write_r4: assert property (@(posedge clk) disable iff (!rst_sn)
    (reg_we_i && reg_addr_i == 2'd1) |=> (en_q == $past(reg_wdata_i)));

  p_rem_clear_r6: assert property (@(posedge clk) disable iff (!rst_sn)
    (reg_we_i && reg_addr_i == 2'd2 && reg_wdata_i[1] && !rem_evt) |=> !pend_q[1]);

  p_ins_wins_r7: assert property (@(posedge clk) disable iff (!rst_sn)
    ins_evt |=> pend_q[0]);

  p_rem_wins_r7: assert property (@(posedge clk) disable iff (!rst_sn)
    rem_evt |=> pend_q[1]);

  p_glob_gate_r8: assert property (@(posedge clk) disable iff (!rst_sn)
    !en_q[2] |-> !irq_o);
endmodule

bind cdi_card_detect cdi_card_detect_chk u_chk (
  .clk         (clk),
  .rst_sn      (rst_sn),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .sync_vec    (sync_vec),
  .deb_present (deb_present),
  .ins_evt     (ins_evt),
  .rem_evt     (rem_evt),
  .en_q        (en_q),
  .pend_q      (pend_q),
  .irq_o       (irq_o)
);

// File: tb/cdi_card_detect_tb.sv
`timescale 1ns/1ps
module cdi_card_detect_tb;
  localparam int DIV    = 4;
  localparam int SETTLE = 2 + 17 * DIV + 30;
  localparam int KIND_IRQ = 4;

  typedef struct {
    int         kind;
    logic [3:0] exp;
    string      tag;
  } item_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pres = 1'b0, wp = 1'b0, busy = 1'b0;
  logic       we = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [2:0] wdata = 3'd0;
  logic [3:0] rdata;
  logic       irq;
  logic       rd_req = 1'b0;
  int         n_chk = 0, n_bad = 0;
  bit         done = 1'b0;
  item_t      sb[$];

  always #2.5 clk = ~clk;

  cdi_card_detect #(.TICK_DIV(DIV), .STABLE_TICKS(16)) u_dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .card_present_i (pres),
    .card_wp_i      (wp),
    .card_busy_i    (busy),
    .reg_we_i       (we),
    .reg_addr_i     (addr),
    .reg_wdata_i    (wdata),
    .reg_rdata_o    (rdata),
    .irq_o          (irq)
  );

  // monitor: compares each queued expectation at the falling edge
  always @(negedge clk) begin
    if (rd_req && sb.size() > 0) begin
      item_t it;
      logic [3:0] act;
      it  = sb.pop_front();
      act = (it.kind == KIND_IRQ) ? {3'b000, irq} : rdata;
      n_chk++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic expect_item(input int kind, input logic [3:0] exp, input string tag);
    item_t it;
    @(posedge clk); #1;
    it.kind = kind; it.exp = exp; it.tag = tag;
    if (kind != KIND_IRQ) addr = kind[1:0];
    sb.push_back(it);
    rd_req = 1'b1;
    @(posedge clk); #1;
    rd_req = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [2:0] d);
    @(posedge clk); #1;
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    we = 1'b0;
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int pulses;
    wait_clk(3); #1;
    rst_n = 1'b1;
    wait_clk(4);

    // R9 reset state, R1 ready with busy low
    expect_item(0, 4'b1000, "R9 R1 status after reset");
    expect_item(1, 4'b0000, "R9 enable after reset");
    expect_item(2, 4'b0000, "R9 events after reset");
    expect_item(KIND_IRQ, 4'b0000, "R9 irq after reset");

    // R1 write-protect and busy through sync
    wp = 1'b1; wait_clk(4);
    expect_item(0, 4'b1010, "R1 write-protect bit");
    wp = 1'b0; busy = 1'b1; wait_clk(4);
    expect_item(0, 4'b0100, "R1 busy set, ready clear");
    busy = 1'b0; wait_clk(4);

    // R4 enable readback
    wr(2'd1, 3'b101);
    expect_item(1, 4'b0101, "R4 enable readback");

    // R2 short glitch ignored
    pres = 1'b1; wait_clk(30); pres = 1'b0;
    wait_clk(SETTLE);
    expect_item(2, 4'b0000, "R2 glitch sets no event");
    expect_item(0, 4'b1000, "R2 glitch leaves presence low");
    expect_item(KIND_IRQ, 4'b0000, "R2 glitch no irq");

    // R2 minimum hold, R3 insert, R5 irq
    pres = 1'b1;
    wait_clk(14 * DIV - 2);
    expect_item(2, 4'b0000, "R2 no event before 16 ticks");
    wait_clk(SETTLE);
    expect_item(2, 4'b0001, "R3 insert event set");
    expect_item(0, 4'b1001, "R1 presence bit after debounce");
    expect_item(KIND_IRQ, 4'b0001, "R5 irq with insert enabled");

    // R6 write-one-to-clear
    wr(2'd2, 3'b010);
    expect_item(2, 4'b0001, "R6 zero bit leaves insert event");
    wr(2'd2, 3'b001);
    expect_item(2, 4'b0000, "R6 insert event cleared");
    expect_item(KIND_IRQ, 4'b0000, "R6 irq drops after clear");

    // R3 remove sets regardless of enable, R8 global gate
    wr(2'd1, 3'b001);
    pres = 1'b0;
    wait_clk(SETTLE);
    expect_item(2, 4'b0010, "R3 remove event while not enabled");
    expect_item(KIND_IRQ, 4'b0000, "R3 irq low when remove not enabled");
    wr(2'd1, 3'b010);
    expect_item(KIND_IRQ, 4'b0000, "R8 global off masks irq");
    wr(2'd1, 3'b110);
    expect_item(KIND_IRQ, 4'b0001, "R5 irq with remove and global");
    wr(2'd1, 3'b100);
    expect_item(KIND_IRQ, 4'b0000, "R5 global alone gives no irq");

    // R10 reserved address and read-only status
    expect_item(3, 4'b0000, "R10 reserved address reads zero");
    wr(2'd0, 3'b111);
    expect_item(0, 4'b1000, "R10 status write ignored");
    expect_item(1, 4'b0100, "R10 status write leaves enable");
    wr(2'd2, 3'b011);
    expect_item(2, 4'b0000, "R6 remove event cleared");

    // R7 event wins over a clear in the same cycle
    wr(2'd1, 3'b101);
    @(posedge clk); #1;
    we = 1'b1; addr = 2'd2; wdata = 3'b001;
    pres = 1'b1;
    pulses = 0;
    for (int i = 0; i < SETTLE; i++) begin
      @(negedge clk);
      if (irq) pulses++;
    end
    @(posedge clk); #1;
    we = 1'b0;
    n_chk++;
    if (pulses != 1) begin
      n_bad++;
      $display("FAIL R7 event vs clear: actual %0d irq cycles expected 1", pulses);
    end
    expect_item(2, 4'b0000, "R7 held clear removes event afterwards");
    expect_item(0, 4'b1001, "R7 presence high after insert");

    wait_clk(2);
    finish_run();
  end
endmodule